// File: doc/BRIEF.md
# Windowed Trigger-to-Readout Selector

This block decides which trace memories are read out for an event. It watches eighteen single-cycle trigger lines. Lines 0 to 15 are per-channel discriminator hits, line 16 is the global acquire trigger and line 17 is the global don't-acquire trigger. Each line owns a programmable selection row. Every bit of a row names one of seventeen memories: the dummy memory, or the memory of one physical channel.

Triggers that fall inside a shared coincidence window are merged by OR-ing their rows. When the window closes, the block emits a one-cycle internal trigger pulse and registers the merged selection mask alongside it. A reduction-enable mask decides which memories may be skipped at all. Any memory whose enable bit is clear is always read out.

Configuration uses a simple synchronous write port. A select code picks a row, the window length or the enable mask, and an index picks the row.

Top module: `trig_select_matrix`

## Requirements
- R1: A write with `cfg_we`=1 and `cfg_sel`=0 stores `cfg_wdata` as the row of source `cfg_idx`. An index of 18 or more changes no row. `cfg_sel`=1 stores `cfg_wdata[15:0]` as the window length W. `cfg_sel`=2 stores `cfg_wdata` as the reduction-enable mask. Every write takes effect from the next cycle.
- R2: Mask bit 0 selects the dummy memory and bit n+1 selects channel n. Source 16 is global acquire and source 17 is global don't-acquire. A lone trigger yields exactly its own row, given that all enables are set.
- R3: Triggers from several sources in the same cycle yield the OR of their rows.
- R4: With W≥1, the first trigger seen while idle in cycle c opens a window. Triggers in cycles c through c+W are merged. `fire_o` is high for exactly one cycle, in cycle c+W+1.
- R5: With W=0 there is no aggregation. A trigger in cycle c gives `fire_o` in cycle c+1 with only the rows of cycle c.
- R6: A trigger in the cycle where `fire_o` is high opens a new window and is not merged into the mask just emitted.
- R7: Each output mask bit is the merged bit OR the inverse of its enable bit.
- R8: A source whose row is zero still opens a window and produces a pulse. `none_o` is high with `fire_o` exactly when the emitted mask is all zeros.
- R9: Reset clears all rows, the window length and the enables. It drives `fire_o` and `none_o` low and `sel_mask_o` to zero.
- R10: `sel_mask_o` holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 row, 1 window, 2 enables |
| cfg_idx | input | 5 | Source index for row writes |
| cfg_wdata | input | 17 | Write data |
| trig_in | input | 18 | Trigger lines, one per source |
| fire_o | output | 1 | One-cycle internal trigger pulse |
| sel_mask_o | output | 17 | Registered readout-select mask |
| none_o | output | 1 | Pulse when the emitted mask selects nothing |

## Verification
The assertions check several properties on every cycle. A zero window always fires on the next cycle. A nonzero window opens without firing. No pulse appears without a trigger or an open window. Every disabled memory shows up as selected, `none_o` never appears without `fire_o`, and the mask is stable between pulses. Only the bench scenarios can show that the emitted masks have the right values and that the bit mapping is correct. They also cover the exact closing cycle of a window, the inclusion of its last cycle, and the separation of a trigger arriving in the pulse cycle.

// File: rtl/trig_select_matrix.sv
module trig_select_matrix #(
  parameter int N_SRC = 18,
  parameter int N_MEM = 17,
  parameter int WIN_W = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [N_MEM-1:0] cfg_wdata,
  input  logic [N_SRC-1:0] trig_in,
  output logic             fire_o,
  output logic [N_MEM-1:0] sel_mask_o,
  output logic             none_o
);
  localparam logic [1:0] SEL_ROW = 2'd0;
  localparam logic [1:0] SEL_WIN = 2'd1;
  localparam logic [1:0] SEL_EN  = 2'd2;

  logic [N_MEM-1:0] row_q [N_SRC];
  logic [WIN_W-1:0] win_q, cnt_q;
  logic [N_MEM-1:0] en_q, acc_q, hit, merged, out_mask;
  logic             busy_q, any_trig, closing;

  for (genvar i = 0; i < N_SRC; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) row_q[i] <= '0;
      else if (cfg_we && cfg_sel == SEL_ROW && cfg_idx == IDX_W'(i)) row_q[i] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
      en_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == SEL_WIN) win_q <= cfg_wdata[WIN_W-1:0];
      if (cfg_sel == SEL_EN)  en_q  <= cfg_wdata;
    end
  end

  always_comb begin
    hit = '0;
    for (int i = 0; i < N_SRC; i++)
      if (trig_in[i]) hit = hit | row_q[i];
  end

  assign any_trig = |trig_in;
  assign merged   = (busy_q ? acc_q : '0) | hit;
  assign out_mask = merged | ~en_q;
  assign closing  = busy_q ? (cnt_q == WIN_W'(1)) : (any_trig && win_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      acc_q      <= '0;
      fire_o     <= 1'b0;
      none_o     <= 1'b0;
      sel_mask_o <= '0;
    end else begin
      fire_o <= closing;
      none_o <= closing && (out_mask == '0);
      if (closing) begin
        sel_mask_o <= out_mask;
        busy_q     <= 1'b0;
        acc_q      <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - WIN_W'(1);
        acc_q <= merged;
      end else if (any_trig) begin
        busy_q <= 1'b1;
        cnt_q  <= win_q;
        acc_q  <= hit;
      end
    end
  end

  AST_ZERO_WIN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && any_trig && win_q == '0) |=> fire_o); // R5
  AST_WIN_OPENS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && any_trig && win_q != '0) |=> (busy_q && !fire_o)); // R4
  AST_FIRE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(busy_q || any_trig)); // R4
  AST_DISABLED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> ((sel_mask_o | $past(en_q)) == {N_MEM{1'b1}})); // R7
  AST_NONE_WITH_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    none_o |-> (fire_o && sel_mask_o == '0)); // R8
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire_o |-> $stable(sel_mask_o)); // R10
endmodule

// File: tb/test_trig_select_matrix.sv
module test_trig_select_matrix;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [4:0]  cfg_idx = '0;
  logic [16:0] cfg_wdata = '0;
  logic [17:0] trig_in = '0;
  logic        fire_o, none_o;
  logic [16:0] sel_mask_o;
  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trig_select_matrix i_trig_select_matrix (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .trig_in(trig_in), .fire_o(fire_o),
    .sel_mask_o(sel_mask_o), .none_o(none_o));

  localparam int NV = 8;
  localparam logic [17:0] V_TRIG [NV] = '{18'h00001, 18'h00003, 18'h08000, 18'h10000,
                                          18'h20000, 18'h08001, 18'h30000, 18'h0AAAA};
  localparam logic [16:0] V_MASK [NV] = '{17'h00002, 17'h00006, 17'h10000, 17'h1FFFF,
                                          17'h00000, 17'h10002, 17'h1FFFF, 17'h15554};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [4:0] idx, logic [16:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_check(string req, logic [17:0] t, logic [16:0] m);
    @(negedge clk); trig_in = t;
    @(negedge clk); trig_in = '0;
    chk({req, " fire"}, 32'(fire_o), 1);
    chk({req, " mask"}, 32'(sel_mask_o), 32'(m));
    chk({req, " none"}, 32'(none_o), 32'(m == '0));
    @(negedge clk);
    chk("R4 single pulse", 32'(fire_o), 0);
    chk("R10 hold", 32'(sel_mask_o), 32'(m));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 fire", 32'(fire_o), 0);
    chk("R9 none", 32'(none_o), 0);
    chk("R9 mask", 32'(sel_mask_o), 0);
    rst_n = 1'b1;
    // R9: rows, window and enables clear -> zero row, all memories forced
    pulse_check("R9 reset enables", 18'h20000, 17'h1FFFF);

    wr(2'd2, 5'd0, 17'h1FFFF);
    for (int i = 0; i < 16; i++) wr(2'd0, 5'(i), 17'(1) << (i + 1));
    wr(2'd0, 5'd16, 17'h1FFFF);
    wr(2'd0, 5'd17, 17'h00000);
    wr(2'd0, 5'd18, 17'h1FFFF); // R1 out-of-range index ignored

    for (int v = 0; v < NV; v++) pulse_check("R2/R3 table", V_TRIG[v], V_MASK[v]);
    pulse_check("R1 idx18 ignored", 18'h00004, 17'h00008);

    wr(2'd0, 5'd5, 17'h00001);
    pulse_check("R2 dummy bit0", 18'h00020, 17'h00001);

    // R4: W=3, triggers in c and c+3 merged; R6: trigger in pulse cycle starts anew
    wr(2'd1, 5'd0, 17'd3);
    @(negedge clk); trig_in = 18'h00001;
    @(negedge clk); chk("R4 early", 32'(fire_o), 0); trig_in = '0;
    @(negedge clk); chk("R4 early", 32'(fire_o), 0);
    @(negedge clk); chk("R4 early", 32'(fire_o), 0); trig_in = 18'h00002;
    @(negedge clk); chk("R4 fire at c+W+1", 32'(fire_o), 1);
    chk("R4 merged mask", 32'(sel_mask_o), 32'h6);
    trig_in = 18'h00004;
    @(negedge clk); chk("R6 no refire", 32'(fire_o), 0); trig_in = '0;
    @(negedge clk); chk("R6 wait", 32'(fire_o), 0);
    @(negedge clk); chk("R6 wait", 32'(fire_o), 0);
    @(negedge clk); chk("R6 new window fire", 32'(fire_o), 1);
    chk("R6 separate mask", 32'(sel_mask_o), 32'h8);

    // R8: zero row opens a window of W=2 and fires with none_o
    wr(2'd1, 5'd0, 17'd2);
    @(negedge clk); trig_in = 18'h20000;
    @(negedge clk); trig_in = '0;
    @(negedge clk); chk("R8 wait", 32'(fire_o), 0);
    @(negedge clk); chk("R8 fire", 32'(fire_o), 1);
    chk("R8 none", 32'(none_o), 1);
    chk("R8 mask", 32'(sel_mask_o), 0);

    // R5: W=0 again; R7: enable bit 0 clear forces dummy
    wr(2'd1, 5'd0, 17'd0);
    wr(2'd2, 5'd0, 17'h1FFFE);
    pulse_check("R7 forced dummy", 18'h00002, 17'h00005);
    pulse_check("R5 zero window", 18'h00001, 17'h00003);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule